// File: doc/BRIEF.md
# Multicycle Eight-Bit Register Processor Core

The core is a small synchronous 8-bit processor with four general registers (A to D), a program counter, a memory address register, a memory buffer register, an instruction register, an ALU and a three-bit flag register. It acts as bus master on a separate address bus and reads 16-bit instruction words from a synchronous memory. The memory returns the addressed word one clock after the read strobe. Each instruction takes five cycles. The first three form the fetch: the PC is copied into the address register, the read cycle increments the PC, and the word is captured into the buffer register. In the fourth cycle the buffer register is copied into the instruction register. In the fifth cycle the operation is executed.

An instruction word holds the operation in bits [15:12], the destination register index in bits [11:10], the source register index in bits [9:8] and an 8-bit immediate in bits [7:0]. The immediate is used only by load-immediate. Register operations are add, subtract, AND, OR, NOT, shift left and shift right. Each one writes its result to the destination register and updates the zero, carry and overflow flags. All other operation codes do nothing. The reset vector is a parameter with a default of 100.

Top module: `mc8_core`

## Requirements
- R1: While reset is low at a clock edge, the PC becomes the start address (100). All registers, the instruction register and the flags become zero, and the read strobe stays low.
- R2: In the second cycle of each instruction the read strobe is high for exactly one cycle, and the address bus carries the PC value that was copied into the address register in the first cycle.
- R3: The PC increases by exactly 1 at the end of the read cycle, once per instruction.
- R4: Every instruction takes five cycles. The fetched word appears on the instruction-register output after the fourth edge, and the result of the instruction is visible after the fifth edge.
- R5: The word encoding is: operation [15:12], destination [11:10], source [9:8], immediate [7:0]. Register index 0 is A, 1 is B, 2 is C and 3 is D. In the register output, register i occupies bits [8i+7:8i].
- R6: Load-immediate (code 1) writes the immediate to the destination register and leaves the flags unchanged.
- R7: Add (code 2) and subtract (code 3) write dst+src and dst−src. Carry is the carry out for add and the borrow for subtract. Overflow is two's-complement overflow.
- R8: AND (4) and OR (5) combine dst with src. NOT (6) writes the complement of src. Shift left (7) and shift right (8) write src shifted by one with a zero filled in, and carry takes the bit shifted out. Carry is 0 for AND, OR and NOT. Overflow is 0 for all five operations.
- R9: The flag output is {overflow, carry, zero}. Zero is set exactly when the written result is 0. The flags change only on operation codes 2 to 8.
- R10: Operation codes 0 and 9 to 15 change no register and no flag.
- R11: Running load A,10 at 100, load B,15 at 101 and add A,B at 102 leaves A at 25, B at 15 and the PC at 103.
- R12: Registers and flags change only at the end of the execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | output | 8 | Address bus, driven from the address register |
| bus_rd | output | 1 | Memory read strobe |
| bus_rdata | input | 16 | Word returned by memory one cycle after the strobe |
| pc_o | output | 8 | Program counter |
| ir_o | output | 16 | Instruction register |
| flags_o | output | 3 | {overflow, carry, zero} |
| regs_o | output | 32 | Registers A to D, A in the low byte |

## Verification
The reference point is the first clock edge after reset is released. The read strobe and the PC address are due after edge 1 of an instruction, the incremented PC after edge 2, the instruction register after edge 4 and the register and flag results after edge 5. A three-instruction program therefore completes on edge 15. The bench counts rising edges from the reset release and samples only on the falling edge after the edge where a value is due. It also samples one edge before a write to confirm that the old value is still held.

// File: rtl/mc8_pkg.sv
// Shared types for the multicycle core: control states, operation codes, flags.
// Assumes a 4-bit operation field; codes not listed here execute as no-ops.
package mc8_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_FETCH_LOAD_IR,
        ST_DECODE,
        ST_EXECUTE
    } state_e;

    localparam logic [3:0] OP_LDI = 4'd1;
    localparam logic [3:0] OP_ADD = 4'd2;
    localparam logic [3:0] OP_SUB = 4'd3;
    localparam logic [3:0] OP_AND = 4'd4;
    localparam logic [3:0] OP_OR  = 4'd5;
    localparam logic [3:0] OP_NOT = 4'd6;
    localparam logic [3:0] OP_SHL = 4'd7;
    localparam logic [3:0] OP_SHR = 4'd8;

    typedef struct packed {
        logic v;
        logic c;
        logic z;
    } flags_t;

endpackage

// File: rtl/mc8_alu.sv
// Combinational ALU. Operand a is the destination register and b is the source.
// Flags the result with zero, carry/borrow and signed overflow.
// Assumes DW >= 2. Sets alu_op only for operation codes that write a result and flags.
module mc8_alu
    import mc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output flags_t        fl,
    output logic          alu_op
);
    localparam int MSB = DW - 1;

    logic [DW:0] sum;
    logic [DW:0] diff;

    // Extended-width add and subtract; the extra bit is the carry or borrow.
    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
    end

    // Select the result and the carry/overflow flags for the operation.
    always_comb begin
        y      = '0;
        fl     = '0;
        alu_op = 1'b1;
        case (op)
            OP_ADD: begin
                y    = sum[DW-1:0];
                fl.c = sum[DW];
                fl.v = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
            end
            OP_SUB: begin
                y    = diff[DW-1:0];
                fl.c = diff[DW];
                fl.v = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
            end
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            OP_NOT: y = ~b;
            OP_SHL: begin
                y    = {b[DW-2:0], 1'b0};
                fl.c = b[MSB];
            end
            OP_SHR: begin
                y    = {1'b0, b[DW-1:1]};
                fl.c = b[0];
            end
            default: alu_op = 1'b0;
        endcase
        fl.z = (y == '0);
    end

endmodule

// File: rtl/mc8_regfile.sv
// General register file: 2**RIW registers of DW bits, one write port and two read ports.
// Assumes at most one write per cycle. All registers clear on synchronous active-low reset.
module mc8_regfile #(
    parameter int DW  = 8,
    parameter int RIW = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [RIW-1:0]          waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [RIW-1:0]          raddr_a,
    input  logic [RIW-1:0]          raddr_b,
    output logic [DW-1:0]           rdata_a,
    output logic [DW-1:0]           rdata_b,
    output logic [(1<<RIW)*DW-1:0]  regs_flat
);
    localparam int NREG = 1 << RIW;

    logic [DW-1:0] rf [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Register g: clears on reset and loads when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rf[g] <= '0;
            else if (we && waddr == RIW'(g))
                rf[g] <= wdata;
        end
        assign regs_flat[g*DW +: DW] = rf[g];
    end

    // Read ports.
    assign rdata_a = rf[raddr_a];
    assign rdata_b = rf[raddr_b];

    // R12: the register contents do not move without a write enable.
    assert_regs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/mc8_ctrl.sv
// Control unit: a five-state sequencer that runs a fetch followed by an execute for every instruction.
// Assumes the memory answers a read one cycle after the strobe and never stalls.
module mc8_ctrl
    import mc8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output state_e state,
    output logic   mar_ld,
    output logic   mem_rd,
    output logic   mbr_ld,
    output logic   ir_ld,
    output logic   exec
);
    state_e nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH_ADDR;
        else        state <= nxt;
    end

    // Fixed sequence; execute always returns to the address step.
    always_comb begin
        case (state)
            ST_FETCH_ADDR:    nxt = ST_FETCH_READ;
            ST_FETCH_READ:    nxt = ST_FETCH_LOAD_IR;
            ST_FETCH_LOAD_IR: nxt = ST_DECODE;
            ST_DECODE:        nxt = ST_EXECUTE;
            default:          nxt = ST_FETCH_ADDR;
        endcase
    end

    // One strobe per state.
    always_comb begin
        mar_ld = (state == ST_FETCH_ADDR);
        mem_rd = (state == ST_FETCH_READ);
        mbr_ld = (state == ST_FETCH_LOAD_IR);
        ir_ld  = (state == ST_DECODE);
        exec   = (state == ST_EXECUTE);
    end

    // R4: execute is always followed by a fresh fetch.
    assert_exec_then_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> state == ST_FETCH_ADDR);

    // R2: the read strobe never lasts more than one cycle.
    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

endmodule

// File: rtl/mc8_core.sv
// Multicycle 8-bit core top. Holds PC, MAR, MBR, IR and the flags, and joins the control unit,
// register file and ALU. Assumes a synchronous memory that returns the addressed word
// on bus_rdata one cycle after bus_rd and holds it until the next read.
module mc8_core
    import mc8_pkg::*;
#(
    parameter int          AW         = 8,
    parameter int          DW         = 8,
    parameter int          RIW        = 2,
    parameter int unsigned START_ADDR = 100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [AW-1:0]          bus_addr,
    output logic                   bus_rd,
    input  logic [DW+7:0]          bus_rdata,
    output logic [AW-1:0]          pc_o,
    output logic [DW+7:0]          ir_o,
    output logic [2:0]             flags_o,
    output logic [(1<<RIW)*DW-1:0] regs_o
);
    localparam int IW = DW + 8;

    logic [AW-1:0] pc_q;
    logic [AW-1:0] mar_q;
    logic [IW-1:0] mbr_q;
    logic [IW-1:0] ir_q;
    flags_t        flags_q;

    state_e        st;
    logic          mar_ld, mem_rd, mbr_ld, ir_ld, exec;

    logic [3:0]     op;
    logic [RIW-1:0] dst, src;
    logic [DW-1:0]  imm;
    logic [DW-1:0]  dval, sval, alu_y;
    flags_t         alu_fl;
    logic           alu_op;
    logic           we;
    logic [DW-1:0]  wdata;

    mc8_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (st),
        .mar_ld (mar_ld),
        .mem_rd (mem_rd),
        .mbr_ld (mbr_ld),
        .ir_ld  (ir_ld),
        .exec   (exec)
    );

    // Split the instruction register into its fields.
    always_comb begin
        op  = ir_q[IW-1 -: 4];
        dst = ir_q[IW-5 -: RIW];
        src = ir_q[IW-5-RIW -: RIW];
        imm = ir_q[DW-1:0];
    end

    // PC: reset vector, then increment during the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= AW'(START_ADDR);
        else if (mem_rd) pc_q <= pc_q + AW'(1);
    end

    // MAR: copy of the PC that drives the address bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      mar_q <= '0;
        else if (mar_ld) mar_q <= pc_q;
    end

    // MBR: capture the word that memory returns.
    always_ff @(posedge clk) begin
        if (!rst_n)      mbr_q <= '0;
        else if (mbr_ld) mbr_q <= bus_rdata;
    end

    // IR: take the fetched word from the MBR.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_ld) ir_q <= mbr_q;
    end

    mc8_regfile #(.DW(DW), .RIW(RIW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (dst),
        .wdata     (wdata),
        .raddr_a   (dst),
        .raddr_b   (src),
        .rdata_a   (dval),
        .rdata_b   (sval),
        .regs_flat (regs_o)
    );

    mc8_alu #(.DW(DW)) u_alu (
        .op     (op),
        .a      (dval),
        .b      (sval),
        .y      (alu_y),
        .fl     (alu_fl),
        .alu_op (alu_op)
    );

    // Write-back select: the immediate for a load, otherwise the ALU result.
    always_comb begin
        we    = exec && (alu_op || op == OP_LDI);
        wdata = (op == OP_LDI) ? imm : alu_y;
    end

    // Flags: updated only by ALU operations in the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                flags_q <= '0;
        else if (exec && alu_op)   flags_q <= alu_fl;
    end

    assign bus_addr = mar_q;
    assign bus_rd   = mem_rd;
    assign pc_o     = pc_q;
    assign ir_o     = ir_q;
    assign flags_o  = flags_q;

    // R2: the address on the bus at the start of a read is the PC from the cycle before.
    assert_addr_from_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> bus_addr == $past(pc_q));

    // R3: each read cycle advances the PC by exactly one.
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> pc_q == $past(pc_q) + AW'(1));

    // R3: the PC does not move outside a read cycle.
    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(pc_q));

    // R12: the flags stay put outside the execute cycle.
    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(flags_o));

endmodule

// File: tb/mc8_core_tb.sv
`timescale 1ns/1ps
module mc8_core_tb_top;

    localparam int START = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr;
    logic        bus_rd;
    logic [15:0] bus_rdata = '0;
    logic [7:0]  pc_o;
    logic [15:0] ir_o;
    logic [2:0]  flags_o;
    logic [31:0] regs_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [15:0] mem [0:255];

    always #4 clk = ~clk;

    mc8_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pc_o      (pc_o),
        .ir_o      (ir_o),
        .flags_o   (flags_o),
        .regs_o    (regs_o)
    );

    // Synchronous memory model: one cycle of read latency.
    always @(posedge clk) if (bus_rd) bus_rdata <= mem[bus_addr];

    // Vectors: {op, A value, B value, expected A, expected {V,C,Z}}; program is LDI A; LDI B; op A,B.
    localparam logic [30:0] VEC [0:12] = '{
        {4'h2, 8'd10,  8'd15,  8'd25,  3'b000},
        {4'h2, 8'hFF,  8'h01,  8'h00,  3'b011},
        {4'h2, 8'h7F,  8'h01,  8'h80,  3'b100},
        {4'h3, 8'h05,  8'h05,  8'h00,  3'b001},
        {4'h3, 8'h03,  8'h05,  8'hFE,  3'b010},
        {4'h3, 8'h80,  8'h01,  8'h7F,  3'b100},
        {4'h4, 8'hF0,  8'h3C,  8'h30,  3'b000},
        {4'h5, 8'h0F,  8'hF0,  8'hFF,  3'b000},
        {4'h6, 8'h12,  8'hFF,  8'h00,  3'b001},
        {4'h7, 8'h12,  8'h81,  8'h02,  3'b010},
        {4'h8, 8'h12,  8'h01,  8'h00,  3'b011},
        {4'hF, 8'h12,  8'h34,  8'h12,  3'b000},
        {4'h0, 8'h56,  8'h34,  8'h56,  3'b000}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [3:0] op);
        if (op == 4'h2 || op == 4'h3) return "R7";
        if (op >= 4'h4 && op <= 4'h8) return "R8";
        return "R10";
    endfunction

    initial begin
        // R1: reset state, sampled while reset is held.
        clear_mem();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc", pc_o, START);
        chk("R1", "regs", regs_o, 0);
        chk("R1", "ir", ir_o, 0);
        chk("R1", "flags", flags_o, 0);
        chk("R1", "rd", bus_rd, 0);

        // R11 sample program with cycle-accurate fetch checks (R2, R3, R4, R12).
        clear_mem();
        mem[START]   = 16'h100A;
        mem[START+1] = 16'h140F;
        mem[START+2] = 16'h2100;
        @(negedge clk) rst_n = 1'b1;
        edges(1);
        chk("R2", "rd after edge 1", bus_rd, 1);
        chk("R2", "addr after edge 1", bus_addr, START);
        chk("R3", "pc during read", pc_o, START);
        edges(1);
        chk("R3", "pc after read", pc_o, START + 1);
        chk("R2", "rd after edge 2", bus_rd, 0);
        edges(2);
        chk("R4", "ir after edge 4", ir_o, 16'h100A);
        chk("R12", "A before execute", regs_o[7:0], 0);
        edges(1);
        chk("R6", "A after load", regs_o[7:0], 8'd10);
        chk("R5", "B untouched", regs_o[15:8], 0);
        edges(9);
        chk("R12", "A before add executes", regs_o[7:0], 8'd10);
        edges(1);
        chk("R11", "A", regs_o[7:0], 8'd25);
        chk("R11", "B", regs_o[15:8], 8'd15);
        chk("R11", "pc", pc_o, START + 3);
        chk("R9", "flags", flags_o, 3'b000);

        // Vector table walk.
        for (int i = 0; i < 13; i++) begin
            logic [3:0] op;
            logic [7:0] av, bv, ey;
            logic [2:0] ef;
            {op, av, bv, ey, ef} = VEC[i];
            clear_mem();
            mem[START]   = {8'h10, av};
            mem[START+1] = {8'h14, bv};
            mem[START+2] = {op, 4'b0001, 8'h00};
            do_reset();
            edges(15);
            chk(tag_of(op), $sformatf("vec %0d A", i), regs_o[7:0], ey);
            chk("R9", $sformatf("vec %0d flags", i), flags_o, ef);
            chk("R5", $sformatf("vec %0d B kept", i), regs_o[15:8], bv);
        end

        // R5: destination C, source D, subtract 7-9.
        clear_mem();
        mem[START]   = 16'h1807;
        mem[START+1] = 16'h1C09;
        mem[START+2] = 16'h3B00;
        do_reset();
        edges(15);
        chk("R5", "C result", regs_o[23:16], 8'hFE);
        chk("R5", "D kept", regs_o[31:24], 8'h09);
        chk("R5", "A untouched", regs_o[7:0], 0);
        chk("R7", "borrow flags", flags_o, 3'b010);

        // R6/R10: load and an undefined code keep the flags set by an earlier add.
        clear_mem();
        mem[START]   = 16'h10FF;
        mem[START+1] = 16'h1401;
        mem[START+2] = 16'h2100;
        mem[START+3] = 16'h1805;
        mem[START+4] = 16'hF100;
        do_reset();
        edges(20);
        chk("R6", "C loaded", regs_o[23:16], 8'h05);
        chk("R6", "flags kept by load", flags_o, 3'b011);
        edges(5);
        chk("R10", "A kept", regs_o[7:0], 8'h00);
        chk("R10", "flags kept", flags_o, 3'b011);
        chk("R3", "pc after five", pc_o, START + 5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule